// File: doc/BRIEF.md
# Compare-Match Toggle Output Channel

This block is a single channel of a counter array, working in high-speed output mode. A shared, free-running timebase count comes in from outside. The channel compares that count with a 16-bit compare value that it holds. On each qualified match, the channel inverts its output pin and sets a sticky match flag. The flag drives an interrupt request when the channel's interrupt enable is set.

Software reaches the channel through a small byte-wide register port. There is a mode register, a low compare byte, a high compare byte and a status byte. A write to the low compare byte switches compare off. A write to the high compare byte switches compare back on. Software writes the low byte first, so a 16-bit update that is only half done can never produce a false match.

A match is counted once for each change of the timebase. The count must change into equality with the compare value. A count that stays at the compare value therefore toggles the pin only once.

Top module: `cmt_channel`

## Requirements
- R1: After reset, `pin_o` is 0, `irq_o` is 0, the compare value is 0, every mode bit is 0 and the match flag is 0.
- R2: The register address map is: 0 = mode, 1 = compare low byte, 2 = compare high byte, 3 = status. In the mode byte, bit 0 is the interrupt enable, bit 1 is the compare enable, bit 2 is the match enable and bit 3 is the toggle enable. In the status byte, bit 0 is the match flag. Unused bits read 0. `rdata_o` shows the addressed register combinationally, and reading changes no state.
- R3: Any write to the compare low byte loads that byte and clears the compare enable to 0 at the same clock edge.
- R4: Any write to the compare high byte loads that byte and sets the compare enable to 1 at the same clock edge.
- R5: A qualified match inverts `pin_o` at the clock edge where it is seen. A qualified match needs two things. First, toggle enable, match enable and compare enable are all 1. Second, `count_i` equals the compare value and differs from its value at the previous edge.
- R6: While `count_i` stays at the compare value, it gives no further match. The same holds when the compare value is changed to equal a count that is not moving.
- R7: If any of toggle enable, match enable or compare enable is 0, a count that equals the compare value leaves `pin_o` and the flag unchanged.
- R8: A qualified match sets the match flag to 1. The flag stays at 1 until software writes status with bit 0 = 0. Writing status with bit 0 = 1 has no effect on the flag.
- R9: `irq_o` is 1 exactly when the match flag is 1 and the interrupt enable is 1.
- R10: If a software clear of the flag and a qualified match fall on the same edge, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_i | input | 16 | Shared timebase count |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| pin_o | output | 1 | Toggle output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle. A low-byte write always disables compare, and a high-byte write always enables it. Every qualified match pulse lands on an equal count that has just changed and flips the pin. A disabled mode leaves the pin still. The flag holds unless a clear is written, and an enabled flag always raises the interrupt. Some behaviour can only be shown by the bench's scenarios. These are the register map and the readback values, a static count toggling only once, the write-1 to status being ignored, and a clear and a match falling on the same edge.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    typedef enum logic [1:0] {
        REG_MODE   = 2'd0,
        REG_CMP_LO = 2'd1,
        REG_CMP_HI = 2'd2,
        REG_STATUS = 2'd3
    } reg_addr_e;

    // Field order gives bit positions: irq_en is bit 0, toggle_en is bit 3
    typedef struct packed {
        logic toggle_en;
        logic match_en;
        logic cmp_en;
        logic irq_en;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    function automatic logic mode_active(mode_t m);
        return m.toggle_en & m.match_en & m.cmp_en;
    endfunction

endpackage

// File: rtl/cmt_regs.sv
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              flag,
    output mode_t             mode,
    output logic [CNT_W-1:0]  cmp,
    output logic              clr_req,
    output logic [BYTE_W-1:0] rdata
);

    reg_addr_e sel;
    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
            cmp  <= '0;
        end else if (wr_en) begin
            case (sel)
                REG_MODE:   mode <= mode_t'(wdata[MODE_W-1:0]);
                REG_CMP_LO: begin
                    cmp[BYTE_W-1:0] <= wdata;
                    mode.cmp_en     <= 1'b0;
                end
                REG_CMP_HI: begin
                    cmp[CNT_W-1:BYTE_W] <= wdata;
                    mode.cmp_en         <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign clr_req = wr_en && (sel == REG_STATUS) && !wdata[0];

    always_comb begin
        rdata = '0;
        case (sel)
            REG_MODE:   rdata[MODE_W-1:0] = mode;
            REG_CMP_LO: rdata = cmp[BYTE_W-1:0];
            REG_CMP_HI: rdata = cmp[CNT_W-1:BYTE_W];
            REG_STATUS: rdata[0] = flag;
            default:    rdata = '0;
        endcase
    end

    assert_lo_write_disables_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == REG_CMP_LO) |=> !mode.cmp_en);

    assert_hi_write_enables_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == REG_CMP_HI) |=> mode.cmp_en);

endmodule

// File: rtl/cmt_match.sv
module cmt_match #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    output logic             hit
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count;
    end

    // One pulse per timebase step into equality
    assign hit = (count == cmp) && (count != count_q);

endmodule

// File: rtl/cmt_out.sv
module cmt_out
    import cmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hit,
    input  mode_t mode,
    input  logic  clr_req,
    output logic  pin,
    output logic  flag,
    output logic  irq
);

    logic fire;
    assign fire = hit && mode_active(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin  <= 1'b0;
            flag <= 1'b0;
        end else begin
            if (fire)         pin <= ~pin;
            if (fire)         flag <= 1'b1;   // hardware set wins over clear
            else if (clr_req) flag <= 1'b0;
        end
    end

    assign irq = flag && mode.irq_en;

    assert_fire_flips_pin_R5: assert property (@(posedge clk) disable iff (rst)
        (hit && mode_active(mode)) |=> (pin != $past(pin)));

    assert_idle_holds_pin_R7: assert property (@(posedge clk) disable iff (rst)
        !mode_active(mode) |=> $stable(pin));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_req) |=> flag);

    assert_fire_sets_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (hit && mode_active(mode)) |=> flag);

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              pin_o,
    output logic              irq_o
);

    mode_t            mode;
    logic [CNT_W-1:0] cmp;
    logic             clr_req;
    logic             flag;
    logic             hit;

    cmt_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .flag(flag), .mode(mode), .cmp(cmp), .clr_req(clr_req), .rdata(rdata_o)
    );

    cmt_match #(.CNT_W(CNT_W)) u_match (
        .clk(clk), .rst(rst), .count(count_i), .cmp(cmp), .hit(hit)
    );

    cmt_out u_out (
        .clk(clk), .rst(rst), .hit(hit), .mode(mode), .clr_req(clr_req),
        .pin(pin_o), .flag(flag), .irq(irq_o)
    );

    assert_hit_on_equal_R6: assert property (@(posedge clk) disable iff (rst)
        hit |-> (count_i == cmp));

    assert_irq_follows_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (flag && mode.irq_en) |-> irq_o);

endmodule

// File: tb/tb_cmt_channel.sv
module tb_cmt_channel;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] count_i = 16'h0000;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata_o;
    logic        pin_o;
    logic        irq_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmt_channel dut (
        .clk(clk), .rst(rst), .count_i(count_i), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata_o(rdata_o), .pin_o(pin_o), .irq_o(irq_o)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata_o;
    endtask

    task automatic step_count(input logic [15:0] v);
        @(negedge clk);
        count_i = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk({7'b0, pin_o}, 8'h00, "R1 pin after reset");
        chk({7'b0, irq_o}, 8'h00, "R1 irq after reset");
        rd(2'd0, d); chk(d, 8'h00, "R1 mode after reset");
        rd(2'd1, d); chk(d, 8'h00, "R1 cmp lo after reset");
        rd(2'd2, d); chk(d, 8'h00, "R1 cmp hi after reset");
        rd(2'd3, d); chk(d, 8'h00, "R1 flag after reset");
    endtask

    task automatic t_interlock();
        logic [7:0] d;
        wr(2'd0, 8'h0F);
        rd(2'd0, d); chk(d, 8'h0F, "R2 mode readback");
        wr(2'd1, 8'h34);
        rd(2'd0, d); chk(d, 8'h0D, "R3 low write clears compare enable");
        rd(2'd1, d); chk(d, 8'h34, "R2 cmp lo readback");
        wr(2'd2, 8'h12);
        rd(2'd0, d); chk(d, 8'h0F, "R4 high write sets compare enable");
        rd(2'd2, d); chk(d, 8'h12, "R2 cmp hi readback");
    endtask

    task automatic t_toggle();
        logic [7:0] d;
        step_count(16'h1233);
        chk({7'b0, pin_o}, 8'h00, "R5 no toggle before match");
        step_count(16'h1234);
        chk({7'b0, pin_o}, 8'h01, "R5 pin toggles on match");
        rd(2'd3, d); chk(d, 8'h01, "R8 flag set on match");
        chk({7'b0, irq_o}, 8'h01, "R9 irq with flag and enable");
        repeat (4) @(negedge clk);
        chk({7'b0, pin_o}, 8'h01, "R6 static count does not retoggle");
        step_count(16'h1235);
        step_count(16'h1234);
        chk({7'b0, pin_o}, 8'h00, "R5 second match toggles back");
        rd(2'd3, d); rd(2'd3, d); chk(d, 8'h01, "R2 read has no side effect on flag");
    endtask

    task automatic t_flag();
        logic [7:0] d;
        wr(2'd0, 8'h0E);
        chk({7'b0, irq_o}, 8'h00, "R9 irq off when enable clear");
        wr(2'd3, 8'h01);
        rd(2'd3, d); chk(d, 8'h01, "R8 write 1 keeps flag");
        wr(2'd3, 8'h00);
        rd(2'd3, d); chk(d, 8'h00, "R8 write 0 clears flag");
        wr(2'd3, 8'h01);
        rd(2'd3, d); chk(d, 8'h00, "R8 write 1 does not set flag");
    endtask

    task automatic t_disabled();
        logic [7:0] d;
        // toggle+match+irq, compare off
        wr(2'd0, 8'h0D);
        step_count(16'h1235);
        step_count(16'h1234);
        chk({7'b0, pin_o}, 8'h00, "R7 no toggle with compare off");
        rd(2'd3, d); chk(d, 8'h00, "R7 no flag with compare off");
        wr(2'd0, 8'h07);
        step_count(16'h1235);
        step_count(16'h1234);
        chk({7'b0, pin_o}, 8'h00, "R7 no toggle with toggle off");
        // low byte alone disables compare
        wr(2'd0, 8'h0F);
        wr(2'd1, 8'h34);
        step_count(16'h1235);
        step_count(16'h1234);
        chk({7'b0, pin_o}, 8'h00, "R3 half update cannot match");
        // high byte written to match a static count: no hit
        wr(2'd2, 8'h12);
        repeat (2) @(negedge clk);
        chk({7'b0, pin_o}, 8'h00, "R6 compare moved onto static count");
    endtask

    task automatic t_race();
        logic [7:0] d;
        step_count(16'h1233);
        @(negedge clk);
        count_i = 16'h1234;
        wr_en = 1'b1; addr = 2'd3; wdata = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        chk({7'b0, pin_o}, 8'h01, "R10 pin toggles during clear");
        rd(2'd3, d); chk(d, 8'h01, "R10 match wins over clear");
        chk({7'b0, irq_o}, 8'h01, "R9 irq follows flag");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_interlock();
        t_toggle();
        t_flag();
        t_disabled();
        t_race();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule